// File: doc/BRIEF.md
# I2C Master Register and FIFO Front-End

This block is the software-facing half of an I2C master controller. A simple 32-bit register bus (write strobe, read strobe, word address, write data, combinational read data) reaches a control word, a target-address register, a byte-count register, a status word and a FIFO flush register. It also reaches two byte-wide FIFOs: software pushes outgoing bytes through one data offset and pops incoming bytes through another. On the other side, a bit-level bus engine sees the start request, direction, byte count, stop suppression and target address. It pops the transmit FIFO and pushes the receive FIFO.

The start request is level-held. It stays asserted after the engine reports completion until software clears it, so software decides when the next transfer begins. A stop-suppress bit lets a write end without a stop condition, which leaves the bus held for a repeated start. A single level interrupt combines three sources: the sticky completion/NACK flag, a transmit FIFO that has drained to its almost-empty level, and a receive FIFO that has filled to its almost-full level. Both levels are programmable fields of the control word.

Top module: `i2cm_regfront`

## Requirements
- R1: After reset the control word, address and count read 0, the irq output is 0, and status reads only bit3 (transmit FIFO empty) plus the live bus lines at bit20 (SCL) and bit21 (SDA).
- R2: The control word at offset 0x00 keeps only bits 0,1,2,3,9,10,11,12-15,16-19 and 20; writing all ones reads back 0x001FFE0F. Unmapped offsets read 0.
- R3: The engine sees start = control bit0 AND control bit2 (enable), read direction = bit3, stop suppression = bit20, count = the low 16 bits of offset 0x08, and target address = bits [7:1] of offset 0x04.
- R4: A completion pulse from the engine does not clear the start bit. It stays 1 until software writes it 0.
- R5: A write to offset 0x10 pushes a byte into a 16-entry transmit FIFO that the engine pops in order. A push while the FIFO is full is dropped.
- R6: A read of offset 0x0C returns and pops the oldest receive byte. A read while the FIFO is empty returns 0 and changes nothing.
- R7: Status bit1 (NACK) and bit2 (interrupt pending) are sticky. An engine NACK sets both, and a completion sets bit2. A status write clears a flag whose bit is written 0 and keeps it when the bit is written 1.
- R8: Status bit0 follows engine busy, bit3 is transmit FIFO empty, bit4 is receive FIFO full, and bits 20/21 follow the live SCL/SDA inputs.
- R9: Writing offset 0x2C with bit0 = 1 empties both FIFOs. With bit0 = 0 the write has no effect.
- R10: irq is 1 whenever status bit2 is set while control bit1 (global interrupt enable) is 1, and is 0 whenever bit1 is 0.
- R11: With control bits 1 and 9 set, irq is 1 when the transmit FIFO level is at or below control field [15:12].
- R12: With control bits 1 and 10 set, irq is 1 when the receive FIFO level is at or above control field [19:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive FIFO at 0x0C) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | Start request to engine |
| eng_read | output | 1 | Direction, 1 = read |
| eng_nostop | output | 1 | Suppress the stop condition |
| eng_count | output | 16 | Transfer byte count |
| eng_addr | output | 7 | 7-bit target address |
| eng_tx_pop | input | 1 | Engine pops transmit FIFO |
| eng_tx_data | output | 8 | Transmit FIFO head byte |
| eng_tx_empty | output | 1 | Transmit FIFO empty |
| eng_rx_push | input | 1 | Engine pushes receive FIFO |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive FIFO full |
| eng_busy | input | 1 | Engine busy |
| eng_done | input | 1 | One-cycle transfer-complete pulse |
| eng_nack | input | 1 | One-cycle NACK pulse |
| scl_in | input | 1 | Live SCL line |
| sda_in | input | 1 | Live SDA line |

## Verification
Most internal faults reach the ports within one cycle. A wrong FIFO pointer or level shows up as a byte out of order or a wrong empty/full status bit on the next pop or status read. A level that is off by one flips irq at one exact fill level, so every level is swept against every threshold value. Sticky-flag faults show up as a status bit or irq that survives, or fails to survive, a status write in the following cycle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_TADDR  = 'h04;
  localparam int OFS_COUNT  = 'h08;
  localparam int OFS_RXD    = 'h0C;
  localparam int OFS_TXD    = 'h10;
  localparam int OFS_STAT   = 'h14;
  localparam int OFS_FLUSH  = 'h2C;

  localparam int CB_START   = 0;
  localparam int CB_GIE     = 1;
  localparam int CB_EN      = 2;
  localparam int CB_READ    = 3;
  localparam int CB_TXE_IE  = 9;
  localparam int CB_RXF_IE  = 10;
  localparam int CB_NOSTOP  = 20;
  localparam int CF_AE_LSB  = 12;
  localparam int CF_AF_LSB  = 16;
  localparam int THR_W      = 4;

  localparam int SB_BUSY    = 1 - 1;
  localparam int SB_NACK    = 1;
  localparam int SB_PEND    = 2;

  localparam logic [31:0] CTRL_MASK = 32'h001F_FE0F;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LW'(DEPTH));
  assign level   = lvl_q;
  assign dout    = mem[rp_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= din;
  end

  // R5: a push into a full FIFO leaves it full, nothing overwritten
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (level == LW'(DEPTH)));

  // R6: a pop from an empty FIFO leaves it empty
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq #(
  parameter int LW    = 5,
  parameter int THR_W = 4
) (
  input  logic             gie,
  input  logic             pend,
  input  logic             txe_ie,
  input  logic             rxf_ie,
  input  logic [THR_W-1:0] ae_lvl,
  input  logic [THR_W-1:0] af_lvl,
  input  logic [LW-1:0]    tx_lvl,
  input  logic [LW-1:0]    rx_lvl,
  output logic             irq
);
  logic tx_low, rx_high;

  always_comb begin
    tx_low  = txe_ie && (tx_lvl <= LW'(ae_lvl));
    rx_high = rxf_ie && (rx_lvl >= LW'(af_lvl));
    irq     = gie && (pend || tx_low || rx_high);
  end
endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
  import i2cm_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic              eng_read,
  output logic              eng_nostop,
  output logic [CNT_W-1:0]  eng_count,
  output logic [6:0]        eng_addr,
  input  logic              eng_tx_pop,
  output logic [7:0]        eng_tx_data,
  output logic              eng_tx_empty,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_data,
  output logic              eng_rx_full,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              scl_in,
  input  logic              sda_in
);
  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  logic [31:0]      ctrl_q, ctrl_d;
  logic [7:0]       taddr_q, taddr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             nack_q, nack_d, pend_q, pend_d;
  logic             wr_ctrl, wr_taddr, wr_cnt, wr_stat, wr_txd, rd_rxd, flush;
  logic [7:0]       rx_dout;
  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic             rx_empty, tx_full;
  logic [31:0]      stat;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_taddr = bus_wr && (bus_addr == ADDR_W'(OFS_TADDR));
  assign wr_cnt   = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_txd   = bus_wr && (bus_addr == ADDR_W'(OFS_TXD));
  assign rd_rxd   = bus_rd && (bus_addr == ADDR_W'(OFS_RXD));
  assign flush    = bus_wr && (bus_addr == ADDR_W'(OFS_FLUSH)) && bus_wdata[0];

  // next-state
  always_comb begin
    ctrl_d  = wr_ctrl  ? (bus_wdata & CTRL_MASK) : ctrl_q;
    taddr_d = wr_taddr ? bus_wdata[7:0]          : taddr_q;
    cnt_d   = wr_cnt   ? bus_wdata[CNT_W-1:0]    : cnt_q;
    nack_d  = eng_nack || (nack_q && !(wr_stat && !bus_wdata[SB_NACK]));
    pend_d  = eng_nack || eng_done ||
              (pend_q && !(wr_stat && !bus_wdata[SB_PEND]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      taddr_q <= '0;
      cnt_q   <= '0;
      nack_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      taddr_q <= taddr_d;
      cnt_q   <= cnt_d;
      nack_q  <= nack_d;
      pend_q  <= pend_d;
    end
  end

  i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wr_txd), .din(bus_wdata[7:0]),
    .pop(eng_tx_pop), .dout(eng_tx_data),
    .level(tx_lvl), .empty(eng_tx_empty), .full(tx_full)
  );

  i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_rxd), .dout(rx_dout),
    .level(rx_lvl), .empty(rx_empty), .full(eng_rx_full)
  );

  i2cm_irq #(.LW(LW), .THR_W(THR_W)) u_irq (
    .gie(ctrl_q[CB_GIE]), .pend(pend_q),
    .txe_ie(ctrl_q[CB_TXE_IE]), .rxf_ie(ctrl_q[CB_RXF_IE]),
    .ae_lvl(ctrl_q[CF_AE_LSB +: THR_W]), .af_lvl(ctrl_q[CF_AF_LSB +: THR_W]),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .irq(irq)
  );

  assign eng_start  = ctrl_q[CB_START] && ctrl_q[CB_EN];
  assign eng_read   = ctrl_q[CB_READ];
  assign eng_nostop = ctrl_q[CB_NOSTOP];
  assign eng_count  = cnt_q;
  assign eng_addr   = taddr_q[7:1];

  always_comb begin
    stat          = '0;
    stat[SB_BUSY] = eng_busy;
    stat[SB_NACK] = nack_q;
    stat[SB_PEND] = pend_q;
    stat[3]       = eng_tx_empty;
    stat[4]       = eng_rx_full;
    stat[20]      = scl_in;
    stat[21]      = sda_in;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):  bus_rdata = ctrl_q;
      ADDR_W'(OFS_TADDR): bus_rdata = {24'd0, taddr_q};
      ADDR_W'(OFS_COUNT): bus_rdata = 32'(cnt_q);
      ADDR_W'(OFS_RXD):   bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
      ADDR_W'(OFS_STAT):  bus_rdata = stat;
      default:            bus_rdata = '0;
    endcase
  end

  // R4: start bit changes only through a control write
  assert_start_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_START] && !wr_ctrl) |=> ctrl_q[CB_START]);

  // R7: a NACK pulse leaves both sticky flags set
  assert_nack_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_nack |=> (nack_q && pend_q));

  // R9: a flush write empties both FIFOs
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (eng_tx_empty && rx_empty));

  // R10: no interrupt without the global enable
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[CB_GIE]);

  // R10: a pending flag with the enable set always interrupts
  assert_irq_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ctrl_q[CB_GIE]) |-> irq);
endmodule

// File: tb/tb_i2cm_regfront.sv
module tb_i2cm_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, eng_start, eng_read, eng_nostop, eng_tx_empty, eng_rx_full;
  logic [15:0] eng_count;
  logic [6:0]  eng_addr;
  logic [7:0]  eng_tx_data;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_busy = 1'b0, eng_done = 1'b0, eng_nack = 1'b0;
  logic        scl_in = 1'b1, sda_in = 1'b1;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  i2cm_regfront dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .eng_start(eng_start), .eng_read(eng_read),
    .eng_nostop(eng_nostop), .eng_count(eng_count), .eng_addr(eng_addr),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_tx_empty(eng_tx_empty), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_nack(eng_nack),
    .scl_in(scl_in), .sda_in(sda_in)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic tx_pop(output logic [7:0] d);
    @(negedge clk); eng_tx_pop = 1'b1; #1 d = eng_tx_data;
    @(negedge clk); eng_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic pulse_done(input logic nk);
    @(negedge clk); eng_done = ~nk; eng_nack = nk;
    @(negedge clk); eng_done = 1'b0; eng_nack = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(6'h00, d); chk("R1 ctrl", d, 0);
    peek(6'h04, d); chk("R1 addr", d, 0);
    peek(6'h08, d); chk("R1 count", d, 0);
    peek(6'h14, d); chk("R1 status", d, 32'h0030_0008);
    chk("R1 irq", irq, 0);

    // R2 control readback mask, unmapped offsets
    wr(6'h00, 32'hFFFF_FFFF); peek(6'h00, d); chk("R2 ctrl ones", d, 32'h001F_FE0F);
    wr(6'h00, 32'h0000_0000); peek(6'h00, d); chk("R2 ctrl zero", d, 0);
    peek(6'h18, d); chk("R2 unmapped", d, 0);
    peek(6'h10, d); chk("R2 txd reads 0", d, 0);

    // R3 engine-facing fields
    wr(6'h00, 32'h0010_000D);
    chk("R3 start", eng_start, 1); chk("R3 read", eng_read, 1); chk("R3 nostop", eng_nostop, 1);
    wr(6'h00, 32'h0000_0001);
    chk("R3 start needs enable", eng_start, 0); chk("R3 write dir", eng_read, 0);
    chk("R3 stop", eng_nostop, 0);
    wr(6'h04, 32'h0000_00B4); chk("R3 target addr", eng_addr, 7'h5A);
    wr(6'h08, 32'hABCD_1234); chk("R3 count", eng_count, 16'h1234);

    // R4 start held after completion
    wr(6'h00, 32'h0000_0005);
    pulse_done(1'b0);
    peek(6'h00, d); chk("R4 start bit held", d[0], 1);
    chk("R4 eng_start held", eng_start, 1);
    wr(6'h00, 32'h0000_0004); chk("R4 cleared by software", eng_start, 0);

    // R7 sticky flags
    peek(6'h14, d); chk("R7 pend after done", d[2:1], 2'b10);
    wr(6'h14, 32'h0000_0006); peek(6'h14, d); chk("R7 write 1 keeps", d[2:1], 2'b10);
    pulse_done(1'b1); peek(6'h14, d); chk("R7 nack sets both", d[2:1], 2'b11);
    wr(6'h14, 32'h0000_0004); peek(6'h14, d); chk("R7 clear nack only", d[2:1], 2'b10);
    wr(6'h14, 32'h0000_0000); peek(6'h14, d); chk("R7 clear pend", d[2:1], 2'b00);

    // R8 live status bits
    eng_busy = 1'b1; scl_in = 1'b0; sda_in = 1'b1;
    peek(6'h14, d); chk("R8 live bits", d, 32'h0020_0009);
    eng_busy = 1'b0; scl_in = 1'b1; sda_in = 1'b0;
    peek(6'h14, d); chk("R8 live bits b", d, 32'h0010_0008);
    sda_in = 1'b1;

    // R5 transmit FIFO order and overflow drop
    for (int i = 0; i < 20; i++) wr(6'h10, 32'(8'h30 + i));
    peek(6'h14, d); chk("R8 tx not empty", d[3], 0);
    for (int i = 0; i < 16; i++) begin
      tx_pop(b); chk("R5 tx order", b, 8'(8'h30 + i));
    end
    chk("R5 tx empty after 16", eng_tx_empty, 1);

    // R6 receive FIFO order and empty read
    for (int i = 0; i < 16; i++) rx_push(8'(8'hA0 + i));
    peek(6'h14, d); chk("R8 rx full", d[4], 1);
    for (int i = 0; i < 16; i++) begin
      rd(6'h0C, d); chk("R6 rx order", d, 32'(8'hA0 + i));
    end
    rd(6'h0C, d); chk("R6 empty read", d, 0);
    rx_push(8'h5C); rd(6'h0C, d); chk("R6 no pop on empty", d, 32'h5C);

    // R9 flush
    wr(6'h10, 32'h11); rx_push(8'h22);
    wr(6'h2C, 32'h0000_0000);
    chk("R9 bit0 zero keeps tx", eng_tx_empty, 0);
    peek(6'h0C, d); chk("R9 bit0 zero keeps rx", d, 32'h22);
    wr(6'h2C, 32'h0000_0001);
    chk("R9 tx flushed", eng_tx_empty, 1);
    peek(6'h0C, d); chk("R9 rx flushed", d, 0);

    // R10 completion interrupt gating
    pulse_done(1'b0);
    wr(6'h00, 32'h0); chk("R10 gie off", irq, 0);
    wr(6'h00, 32'h2); chk("R10 gie on", irq, 1);
    wr(6'h14, 32'h0); chk("R10 cleared", irq, 0);

    // R11 sweep every almost-empty level against every tx level
    for (int ae = 0; ae < 16; ae++) begin
      wr(6'h2C, 32'h1);
      wr(6'h00, 32'h0000_0202 | (32'(ae) << 12));
      for (int lvl = 0; lvl <= 16; lvl++) begin
        chk("R11 tx level irq", irq, (lvl <= ae) ? 1 : 0);
        if (lvl < 16) wr(6'h10, 32'(lvl));
      end
    end
    wr(6'h00, 32'h0000_0002 | (32'd15 << 12));
    chk("R11 enable off", irq, 0);

    // R12 sweep every almost-full level against every rx level
    for (int af = 0; af < 16; af++) begin
      wr(6'h2C, 32'h1);
      wr(6'h00, 32'h0000_0402 | (32'(af) << 16));
      for (int lvl = 0; lvl <= 16; lvl++) begin
        chk("R12 rx level irq", irq, (lvl >= af) ? 1 : 0);
        if (lvl < 16) rx_push(8'(lvl));
      end
    end
    wr(6'h00, 32'h0000_0400);
    chk("R12 gie off", irq, 0);

    finish_run();
  end
endmodule